// File: doc/BRIEF.md
# Timer with Shared Watchdog Prescaler

This block is an 8-bit up-counting timer. Control inputs pick what it counts: every instruction cycle (one `clk` period), edges on an external input pin, or edges of a comparator output. A single power-of-two prescaler sits between the count source and the timer. The prescaler belongs either to the timer or to a watchdog tick path, and never to both at once. The path that does not own it runs undivided.

The external pin and the comparator output are asynchronous. Each passes through a two-stage synchronizer and then an edge detector before it can count. Software loads the timer through a write port. A load clears the prescaler when the timer owns it, and it blocks counting for the next two cycles. The watchdog oscillator is outside the block: its base tick comes in on `wdt_base_tick`, and the block returns the prescaled or direct tick on `wdt_tick`. The timer wraps from 0xFF to 0x00 and has no interrupt.

Top module: `tmr_wdt_shared`

## Requirements
- R1: After reset, `count` is 0x00 and `wdt_tick` is 0.
- R2: With `wr_en` high at a rising edge, `count` equals `wr_data` after that edge. If `ctl_psa`=0, the prescaler is cleared at the same edge.
- R3: After a load, the two following edges do not advance `count`. The first increment can come on the third edge after the load.
- R4: With `ctl_cmp_en`=0 and `ctl_src_ext`=0, the count source gives one event every cycle, and activity on `ext_clk_in` is ignored.
- R5: A change on `ext_clk_in` made before rising edge A is counted at edge A+2 at the earliest, through two synchronizer stages and an edge detector. This applies with the timer undivided.
- R6: With `ctl_src_ext`=1, `ctl_edge_fall`=0 counts rising edges of `ext_clk_in` and `ctl_edge_fall`=1 counts falling edges.
- R7: With `ctl_cmp_en`=1, edges of `cmp_in` are counted, using the polarity set by `ctl_edge_fall`. `ext_clk_in` is ignored whatever `ctl_src_ext` holds.
- R8: With `ctl_psa`=0 (timer owns the prescaler), the timer advances once per 2^(`ctl_rate`+1) source events. Code 0 gives 1:2 and code 7 gives 1:256.
- R9: With `ctl_psa`=0, `wdt_tick` pulses once for every `wdt_base_tick`, one cycle later, whatever the value of `ctl_rate`.
- R10: With `ctl_psa`=1 (watchdog owns the prescaler), `wdt_tick` pulses once per 2^`ctl_rate` base ticks. Code 0 gives 1:1 and code 7 gives 1:128. In this mode the timer counts source events undivided.
- R11: `count` advances by exactly one per counted event and wraps from 0xFF to 0x00.
- R12: In a cycle where `ctl_psa` differs from its value in the previous cycle, the prescaler is cleared. Timer and watchdog events in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_src_ext | input | 1 | 1 selects the external pin as count source, 0 selects the instruction clock |
| ctl_edge_fall | input | 1 | 1 counts falling edges, 0 counts rising edges of the pin or comparator |
| ctl_cmp_en | input | 1 | 1 makes the comparator output the count source |
| ctl_psa | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| ctl_rate | input | 3 | Prescaler rate code |
| ext_clk_in | input | 1 | Asynchronous external count input |
| cmp_in | input | 1 | Asynchronous comparator output |
| wdt_base_tick | input | 1 | One-cycle tick from the watchdog oscillator domain, already synchronized |
| wr_en | input | 1 | Timer load strobe |
| wr_data | input | 8 | Timer load value |
| count | output | 8 | Current timer value |
| wdt_tick | output | 1 | Prescaled or direct watchdog tick |

## Verification
A load can land in the same cycle as a source event that would have advanced the timer or the prescaler. The bench provokes this by loading while the instruction clock counts every cycle. It expects the loaded value with no increment, followed by exactly two idle edges and then the divided count from a cleared prescaler. A switch of prescaler ownership can also coincide with both a timer event and a watchdog tick. The bench flips ownership twice in adjacent cycles with the prescaler part-filled. It judges the result by where the next timer increment falls, which shows whether the clear happened.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Mask of the n low bits set; saturates at 32 bits.
  function automatic logic [31:0] low_ones(input int unsigned n);
    if (n >= 32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction

  // Pick one detected edge by polarity select.
  function automatic logic edge_pick(input logic rise, input logic fall,
                                     input logic use_fall);
    return use_fall ? fall : rise;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel (
  input  logic sel_ext,
  input  logic edge_fall,
  input  logic cmp_en,
  input  logic ext_rise,
  input  logic ext_fall,
  input  logic cmp_rise,
  input  logic cmp_fall,
  output logic pulse
);
  logic ext_evt;
  logic cmp_evt;

  assign ext_evt = tmr_pkg::edge_pick(ext_rise, ext_fall, edge_fall);
  assign cmp_evt = tmr_pkg::edge_pick(cmp_rise, cmp_fall, edge_fall);

  always_comb begin
    if (cmp_en)       pulse = cmp_evt;
    else if (sel_ext) pulse = ext_evt;
    else              pulse = 1'b1;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int RATE_W = 3,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pulse_in,
  input  logic [RATE_W-1:0] rate,
  output logic [PRE_W-1:0]  cnt,
  output logic              carry_tmr,
  output logic              carry_wdt
);
  logic [PRE_W-1:0] mask_tmr;
  logic [PRE_W-1:0] mask_wdt;

  assign mask_tmr = PRE_W'(tmr_pkg::low_ones(int'(rate) + 1));
  assign mask_wdt = PRE_W'(tmr_pkg::low_ones(int'(rate)));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (pulse_in) cnt <= cnt + 1'b1;
  end

  // Carry out of the selected stage: the incoming pulse finds all lower stages full.
  assign carry_tmr = pulse_in & ((cnt & mask_tmr) == mask_tmr);
  assign carry_wdt = pulse_in & ((cnt & mask_wdt) == mask_wdt);
endmodule

// File: rtl/tmr_wdt_shared.sv
module tmr_wdt_shared #(
  parameter int CNT_W       = 8,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_src_ext,
  input  logic              ctl_edge_fall,
  input  logic              ctl_cmp_en,
  input  logic              ctl_psa,
  input  logic [RATE_W-1:0] ctl_rate,
  input  logic              ext_clk_in,
  input  logic              cmp_in,
  input  logic              wdt_base_tick,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              wdt_tick
);
  localparam int PRE_W  = 1 << RATE_W;
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam int N_CH   = 2;

  logic [N_CH-1:0]   raw_in;
  logic [N_CH-1:0]   rise_v;
  logic [N_CH-1:0]   fall_v;
  logic              src_pulse;
  logic              psa_q;
  logic              assign_chg;
  logic [HOLD_W-1:0] hold_cnt;
  logic              hold_active;
  logic              pre_in;
  logic              pre_clr;
  logic [PRE_W-1:0]  pre_cnt;
  logic              carry_tmr;
  logic              carry_wdt;
  logic              tmr_inc;
  logic              wdt_evt;
  logic [CNT_W-1:0]  count_q;
  logic              wdt_q;

  assign raw_in = {cmp_in, ext_clk_in};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[ch]),
      .rise (rise_v[ch]),
      .fall (fall_v[ch])
    );
  end

  tmr_src_sel u_src (
    .sel_ext  (ctl_src_ext),
    .edge_fall(ctl_edge_fall),
    .cmp_en   (ctl_cmp_en),
    .ext_rise (rise_v[0]),
    .ext_fall (fall_v[0]),
    .cmp_rise (rise_v[1]),
    .cmp_fall (fall_v[1]),
    .pulse    (src_pulse)
  );

  // Ownership tracking
  always_ff @(posedge clk) begin
    if (!rst_n) psa_q <= 1'b0;
    else        psa_q <= ctl_psa;
  end
  assign assign_chg = ctl_psa ^ psa_q;

  // Post-load increment hold
  always_ff @(posedge clk) begin
    if (!rst_n)           hold_cnt <= '0;
    else if (wr_en)       hold_cnt <= HOLD_W'(HOLD_CYCLES);
    else if (hold_active) hold_cnt <= hold_cnt - HOLD_W'(1);
  end
  assign hold_active = (hold_cnt != '0);

  // Prescaler input routing
  assign pre_clr = assign_chg | (wr_en & ~ctl_psa);
  assign pre_in  = ~assign_chg &
                   (ctl_psa ? wdt_base_tick : (src_pulse & ~hold_active & ~wr_en));

  tmr_prescaler #(.RATE_W(RATE_W), .PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pre_clr),
    .pulse_in (pre_in),
    .rate     (ctl_rate),
    .cnt      (pre_cnt),
    .carry_tmr(carry_tmr),
    .carry_wdt(carry_wdt)
  );

  assign tmr_inc = ~assign_chg & ~wr_en &
                   (ctl_psa ? (src_pulse & ~hold_active) : carry_tmr);
  assign wdt_evt = ~assign_chg & (ctl_psa ? carry_wdt : wdt_base_tick);

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (wr_en)   count_q <= wr_data;
    else if (tmr_inc) count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wdt_q <= 1'b0;
    else        wdt_q <= wdt_evt;
  end

  assign count    = count_q;
  assign wdt_tick = wdt_q;
endmodule

// File: rtl/tmr_wdt_shared_chk.sv
module tmr_wdt_shared_chk #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count,
  input logic             ctl_psa,
  input logic             ctl_src_ext,
  input logic             ctl_cmp_en,
  input logic             wdt_base_tick,
  input logic             wdt_tick,
  input logic             assign_chg,
  input logic             hold_active,
  input logic             src_pulse,
  input logic [PRE_W-1:0] pre_cnt
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));

  assert_preclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_psa) |=> pre_cnt == '0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !wr_en) |=> count == $past(count));

  assert_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_cmp_en && !ctl_src_ext) |-> src_pulse);

  assert_wdt_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_psa && !assign_chg) |=> wdt_tick == $past(wdt_base_tick));

  assert_direct_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_psa && src_pulse && !hold_active && !wr_en && !assign_chg)
      |=> count == CNT_W'($past(count) + 1'b1));

  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

  assert_chgclr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    assign_chg |=> pre_cnt == '0);
endmodule

bind tmr_wdt_shared tmr_wdt_shared_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .count        (count),
  .ctl_psa      (ctl_psa),
  .ctl_src_ext  (ctl_src_ext),
  .ctl_cmp_en   (ctl_cmp_en),
  .wdt_base_tick(wdt_base_tick),
  .wdt_tick     (wdt_tick),
  .assign_chg   (assign_chg),
  .hold_active  (hold_active),
  .src_pulse    (src_pulse),
  .pre_cnt      (pre_cnt)
);

// File: tb/tb_tmr_wdt_shared.sv
`timescale 1ns/1ps
module tb_tmr_wdt_shared;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_src_ext = 1'b0;
  logic       ctl_edge_fall = 1'b0;
  logic       ctl_cmp_en = 1'b0;
  logic       ctl_psa = 1'b0;
  logic [2:0] ctl_rate = 3'd0;
  logic       ext_clk_in = 1'b0;
  logic       cmp_in = 1'b0;
  logic       wdt_base_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] count;
  logic       wdt_tick;

  int total = 0;
  int fails = 0;
  int wdt_seen = 0;
  bit wdt_win = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_wdt_shared dut (
    .clk(clk), .rst_n(rst_n), .ctl_src_ext(ctl_src_ext), .ctl_edge_fall(ctl_edge_fall),
    .ctl_cmp_en(ctl_cmp_en), .ctl_psa(ctl_psa), .ctl_rate(ctl_rate),
    .ext_clk_in(ext_clk_in), .cmp_in(cmp_in), .wdt_base_tick(wdt_base_tick),
    .wr_en(wr_en), .wr_data(wr_data), .count(count), .wdt_tick(wdt_tick)
  );

  always @(negedge clk) if (wdt_win && wdt_tick) wdt_seen++;

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input logic sx, input logic fe, input logic ce,
                     input logic pa, input logic [2:0] rt);
    ctl_src_ext = sx; ctl_edge_fall = fe; ctl_cmp_en = ce;
    ctl_psa = pa; ctl_rate = rt;
    cyc(3);
  endtask

  // Returns at the falling edge after the loading edge.
  task automatic load(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic toggle_ext(input int n);
    for (int i = 0; i < n; i++) begin ext_clk_in = ~ext_clk_in; cyc(4); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state (count may have stepped once after release)
    check(wdt_tick, 0, "R1 wdt_tick");
    rst_n = 1'b0; cyc(1);
    check(count, 8'h00, "R1 count");
    rst_n = 1'b1;

    // R3: load hold with undivided internal source
    cfg(0, 0, 0, 1, 3'd0);
    load(8'h50);
    check(count, 8'h50, "R2 load");
    cyc(1); check(count, 8'h50, "R3 hold edge 1");
    cyc(1); check(count, 8'h50, "R3 hold edge 2");
    cyc(1); check(count, 8'h51, "R3 first increment");

    // R8: timer-owned prescaler sweep, load collides with running source
    for (int r = 0; r < 8; r++) begin
      int dv;
      dv = 2 << r;
      cfg(0, 0, 0, 0, 3'(r));
      load(8'h10);
      check(count, 8'h10, "R2 load under prescaler");
      cyc(2 + 2 * dv - 1); check(count, 8'h11, $sformatf("R8 rate %0d before 2nd", r));
      cyc(1);              check(count, 8'h12, $sformatf("R8 rate %0d at 2nd", r));
    end

    // R10 timer side + R4: undivided internal count, rate ignored, ext ignored
    for (int r = 0; r < 8; r++) begin
      cfg(0, 0, 0, 1, 3'(r));
      load(8'h20);
      fork toggle_ext(2); join_none
      cyc(2 + 5);
      check(count, 8'h25, $sformatf("R10/R4 direct count rate %0d", r));
      cyc(3);
    end

    // R11 wrap
    cfg(0, 0, 0, 1, 3'd4);
    load(8'hFD);
    cyc(2 + 3); check(count, 8'h00, "R11 wrap to 00");
    cyc(1);     check(count, 8'h01, "R11 after wrap");

    // R10 watchdog side: divide by 2^rate
    for (int r = 0; r < 8; r++) begin
      int t;
      t = 4 << r;
      cfg(0, 0, 0, 0, 3'(r));
      cfg(0, 0, 0, 1, 3'(r));
      wdt_seen = 0; wdt_win = 1'b1;
      wdt_base_tick = 1'b1; cyc(t);
      wdt_base_tick = 1'b0; cyc(4);
      wdt_win = 1'b0;
      check(wdt_seen, 4, $sformatf("R10 wdt rate %0d", r));
    end

    // R9: timer owns prescaler, watchdog 1:1
    cfg(0, 0, 0, 0, 3'd5);
    wdt_seen = 0; wdt_win = 1'b1;
    wdt_base_tick = 1'b1; cyc(10);
    wdt_base_tick = 1'b0; cyc(4);
    wdt_win = 1'b0;
    check(wdt_seen, 10, "R9 wdt direct");

    // R5: synchronizer latency
    ext_clk_in = 1'b0;
    cfg(1, 0, 0, 1, 3'd0);
    load(8'h40);
    cyc(4);
    ext_clk_in = 1'b1;
    cyc(2); check(count, 8'h40, "R5 not before A+2");
    cyc(1); check(count, 8'h41, "R5 at A+2");
    ext_clk_in = 1'b0; cyc(4);

    // R6: rising vs falling, 9 toggles from low = 5 rises, 4 falls
    cfg(1, 0, 0, 1, 3'd0);
    load(8'h00); cyc(3);
    toggle_ext(9); cyc(5);
    check(count, 5, "R6 rising edges");
    ext_clk_in = 1'b0; cyc(5);
    cfg(1, 1, 0, 1, 3'd0);
    load(8'h00); cyc(3);
    toggle_ext(9); cyc(5);
    check(count, 4, "R6 falling edges");
    ext_clk_in = 1'b0; cyc(5);

    // R7: comparator source overrides pin source
    cmp_in = 1'b0;
    cfg(1, 0, 1, 1, 3'd0);
    load(8'h00); cyc(3);
    for (int i = 0; i < 10; i++) begin
      ext_clk_in = ~ext_clk_in;
      if (i < 6) cmp_in = ~cmp_in;
      cyc(4);
    end
    cyc(5);
    check(count, 3, "R7 comparator rises only");

    // R12: ownership flip clears prescaler
    cfg(0, 0, 0, 0, 3'd1);
    load(8'h00);
    cyc(2 + 3);
    check(count, 8'h00, "R12 prescaler part-filled");
    ctl_psa = 1'b1; cyc(1);
    ctl_psa = 1'b0; cyc(1);
    check(count, 8'h00, "R12 flip drops events");
    cyc(3); check(count, 8'h00, "R12 cleared, 3 events");
    cyc(1); check(count, 8'h01, "R12 cleared, 4th event");

    finish_run();
  end
endmodule